// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block connects an asynchronous 16-bit parallel host bus to an internal register file clocked by the core clock. Chip enable, read and write controls are brought into the core domain through synchronizer chains. Edge detection after the chain turns each host access into a single register operation. The data bus is split into an input half, an output half and an output enable, so a bidirectional pad can be built outside the block.

A static mode input selects how the read pin is interpreted. When the mode input is low, the read pin is an active-low read strobe and a separate active-low write strobe performs writes. When the mode input is high, the read pin is a direction line that is high for a read and low for a write, and the separate write strobe is ignored. Chip enable is active low in both modes.

A second, independent part produces a data-ready interrupt. A single-cycle event from the core starts a pulse whose length in clock cycles comes from a configuration input. A new event that arrives during a pulse starts the count again.

Top module: `host_reg_port`

## Requirements
- R1: In strobe mode (mode input = 0), with chip enable and the read pin both held low, data_oe goes to 1 within three clocks and data_out shows the register selected by addr.
- R2: In strobe mode, a low level on the write strobe while chip enable is low stores data_in into the register selected by addr.
- R3: In direction mode (mode input = 1), with chip enable low, a high read/direction pin reads the addressed register onto data_out with data_oe = 1, and a low read/direction pin writes data_in into it.
- R4: In direction mode the separate write strobe has no effect: asserting it during a read access leaves the register contents unchanged.
- R5: While chip enable is high, neither strobe writes a register and data_oe stays 0.
- R6: data_oe returns to 0 within three clocks after the read access ends.
- R7: Each access performs exactly one write. The value captured is the value of data_in when the start of the access is detected, and later changes of data_in during the same access are not stored.
- R8: A data_ready pulse with irq_len = N > 0 makes irq high for exactly N consecutive cycles, starting the cycle after the event.
- R9: A data_ready pulse that arrives while irq is high reloads the count, so irq then stays high for irq_len more cycles.
- R10: With irq_len = 0, a data_ready pulse produces no interrupt.
- R11: After reset, data_oe and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_rw | input | 1 | 0: strobe mode, 1: direction mode (static) |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| rd_n | input | 1 | Read strobe (mode 0) or read-high/write-low line (mode 1) |
| wr_n | input | 1 | Write strobe, active low, used in mode 0 only |
| addr | input | ADDR_W | Register address, same timing as ce_n |
| data_in | input | DATA_W | Write data from the host |
| data_out | output | DATA_W | Read data to the host |
| data_oe | output | 1 | Output enable for the data pad |
| data_ready | input | 1 | Single-cycle core event |
| irq_len | input | CNT_W | Interrupt pulse length in cycles |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume that addr and data_in are stable while an access is active, that mode_rw is held constant for the whole access, and that data_ready is a synchronous single-cycle pulse. The stimulus sets addr, data_in and the direction line before it lowers chip enable, and holds each access for five clocks. It leaves five idle clocks between accesses, so every access passes the synchronizers and the edge detect before the next one begins. The one exception is the test for R7, where data_in is changed on purpose after the write has already been captured.

// File: rtl/host_if_pkg.sv
package host_if_pkg;
  typedef enum logic {
    MODE_STROBE = 1'b0,
    MODE_DIR    = 1'b1
  } host_mode_e;

  typedef struct packed {
    logic ce_n;
    logic rd_n;
    logic wr_n;
  } host_ctrl_t;

  localparam int CTRL_W = 3;
endpackage

// File: rtl/host_sync.sv
module host_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= IDLE;
      else if (s == 0) chain[s] <= async_in;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/host_access_decode.sv
module host_access_decode
  import host_if_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  host_mode_e mode,
  input  host_ctrl_t ctrl_s,
  output logic       wr_stb,
  output logic       rd_oe
);
  logic rd_act, wr_act, wr_act_q;

  always_comb begin
    if (mode == MODE_DIR) begin
      rd_act = !ctrl_s.ce_n &&  ctrl_s.rd_n;
      wr_act = !ctrl_s.ce_n && !ctrl_s.rd_n;
    end else begin
      rd_act = !ctrl_s.ce_n && !ctrl_s.rd_n;
      wr_act = !ctrl_s.ce_n && !ctrl_s.wr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q <= 1'b0;
      rd_oe    <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_oe    <= rd_act;
    end
  end

  assign wr_stb = wr_act && !wr_act_q;

  assert_one_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  assert_oe_needs_ce_R5: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> $past(!ctrl_s.ce_n));
  assert_no_write_ce_high_R5: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_s.ce_n) && ctrl_s.ce_n |-> !wr_stb);
endmodule

// File: rtl/host_regfile.sv
module host_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             event_in,
  input  logic [CNT_W-1:0] len,
  output logic             irq
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) remain <= '0;
    else if (event_in) remain <= len;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign irq = (remain != '0);

  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (rst)
    event_in && (len != '0) |=> irq);
  assert_pulse_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(event_in));
  assert_pulse_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !event_in && (remain > 1) |=> irq);
  assert_zero_len_R10: assert property (@(posedge clk) disable iff (rst)
    event_in && (len == '0) |=> !irq);
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import host_if_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_rw,
  input  logic              ce_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              data_ready,
  input  logic [CNT_W-1:0]  irq_len,
  output logic              irq
);
  host_ctrl_t ctrl_raw, ctrl_s;
  logic       wr_stb;
  host_mode_e mode;

  assign mode     = host_mode_e'(mode_rw);
  assign ctrl_raw = '{ce_n: ce_n, rd_n: rd_n, wr_n: wr_n};

  host_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
    .clk(clk), .rst(rst), .async_in(ctrl_raw), .sync_out(ctrl_s)
  );

  host_access_decode u_dec (
    .clk(clk), .rst(rst), .mode(mode), .ctrl_s(ctrl_s),
    .wr_stb(wr_stb), .rd_oe(data_oe)
  );

  host_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .we(wr_stb), .addr(addr), .wdata(data_in), .rdata(data_out)
  );

  irq_pulse_gen #(.CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst(rst), .event_in(data_ready), .len(irq_len), .irq(irq)
  );

  assert_wr_strobe_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DIR) && ctrl_s.rd_n |-> !wr_stb);
  assert_no_oe_during_write_R3: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !data_oe);
endmodule

// File: tb/test_host_reg_port.sv
module test_host_reg_port;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_rw = 1'b0, ce_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_out;
  logic data_oe, data_ready = 1'b0, irq;
  logic [CW-1:0] irq_len = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  host_reg_port #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .CNT_W(CW)) i_host_reg_port (
    .clk(clk), .rst(rst), .mode_rw(mode_rw), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .data_ready(data_ready), .irq_len(irq_len), .irq(irq)
  );

  // {mode, is_write, addr, data}; for reads data is the expected value
  localparam logic [21:0] VEC [8] = '{
    {1'b0, 1'b1, 4'h3, 16'h1234},
    {1'b1, 1'b1, 4'h5, 16'hBEEF},
    {1'b0, 1'b0, 4'h5, 16'hBEEF},
    {1'b1, 1'b0, 4'h3, 16'h1234},
    {1'b0, 1'b1, 4'hF, 16'hFFFF},
    {1'b1, 1'b0, 4'hF, 16'hFFFF},
    {1'b1, 1'b1, 4'h0, 16'h0001},
    {1'b0, 1'b0, 4'h0, 16'h0001}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_bus();
    ce_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    idle(5);
  endtask

  task automatic start_access(input logic m, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    mode_rw = m; addr = a; data_in = d;
    if (m) rd_n = !wr;
    else if (wr) wr_n = 1'b0;
    else rd_n = 1'b0;
    ce_n = 1'b0;
    idle(5);
  endtask

  task automatic read_check(input logic m, input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    start_access(m, 1'b0, a, '0);
    check(data_oe === 1'b1, req, {31'd0, data_oe}, 32'd1);
    check(data_out === exp, req, {16'd0, data_out}, {16'd0, exp});
    release_bus();
    check(data_oe === 1'b0, "R6", {31'd0, data_oe}, 32'd0);
  endtask

  task automatic pulse_event();
    data_ready = 1'b1;
    @(negedge clk);
    data_ready = 1'b0;
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    check(data_oe === 1'b0, "R11", {31'd0, data_oe}, 32'd0);
    check(irq === 1'b0, "R11", {31'd0, irq}, 32'd0);

    // vector table: R1/R2 in mode 0, R3 in mode 1
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][20]) begin
        start_access(VEC[i][21], 1'b1, VEC[i][19:16], VEC[i][15:0]);
        release_bus();
      end else begin
        read_check(VEC[i][21], VEC[i][19:16], VEC[i][15:0], VEC[i][21] ? "R3" : "R1");
      end
    end

    // R4: write strobe ignored in direction mode during a read
    mode_rw = 1'b1; addr = 4'h3; data_in = 16'hDEAD; rd_n = 1'b1; wr_n = 1'b0; ce_n = 1'b0;
    idle(5);
    release_bus();
    read_check(1'b1, 4'h3, 16'h1234, "R4");

    // R5: chip enable high blocks write and output enable
    mode_rw = 1'b0; addr = 4'h5; data_in = 16'h0BAD; wr_n = 1'b0; rd_n = 1'b0;
    idle(6);
    check(data_oe === 1'b0, "R5", {31'd0, data_oe}, 32'd0);
    release_bus();
    read_check(1'b0, 4'h5, 16'hBEEF, "R5");

    // R7: data captured at start of access, later changes ignored
    start_access(1'b0, 1'b1, 4'h7, 16'hAAAA);
    data_in = 16'h5555;
    idle(5);
    release_bus();
    read_check(1'b0, 4'h7, 16'hAAAA, "R7");

    // R8: pulse of exactly 3 cycles
    irq_len = 8'd3;
    pulse_event();
    for (int k = 0; k < 3; k++) check(irq === 1'b1, "R8", {31'd0, irq}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 0) @(negedge clk);
    end
    idle(1);
    idle(10);

    // R8 precise window
    pulse_event();
    check(irq === 1'b1, "R8", {31'd0, irq}, 32'd1);
    @(negedge clk); check(irq === 1'b1, "R8", {31'd0, irq}, 32'd1);
    @(negedge clk); check(irq === 1'b1, "R8", {31'd0, irq}, 32'd1);
    @(negedge clk); check(irq === 1'b0, "R8", {31'd0, irq}, 32'd0);
    idle(5);

    // R9: restart during pulse
    irq_len = 8'd4;
    pulse_event();
    idle(1);
    pulse_event();
    for (int k = 0; k < 4; k++) begin
      check(irq === 1'b1, "R9", {31'd0, irq}, 32'd1);
      @(negedge clk);
    end
    check(irq === 1'b0, "R9", {31'd0, irq}, 32'd0);
    idle(5);

    // R10: zero length gives no pulse
    irq_len = 8'd0;
    pulse_event();
    for (int k = 0; k < 3; k++) begin
      check(irq === 1'b0, "R10", {31'd0, irq}, 32'd0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule